// File: doc/BRIEF.md
# Sector Hamming Code Generator and Checker

This block computes a single-error-correcting line/column parity code over a sector of bytes fed in one per cycle. Each data bit has a bit address made of its byte index and its bit number within the byte. For each bit of that address, the block keeps two running parities. One covers every data bit whose address bit is one, the other every data bit whose address bit is zero. With the default 512-byte sector the address is 12 bits wide, so the code is 24 bits.

The two 12-bit halves are joined and inverted to form the stored code. Because of the inversion, a sector of all-ones bytes produces an all-ones code, so an erased sector together with its erased spare area checks clean.

To check a sector on read-back, the host streams the sector through the block and then presents the code that was stored with it. The block XORs the stored code with the fresh one and reports one of three results. The sector is clean. Or a single bit was corrected: if the bad bit is in the data, the block gives the byte index and a one-hot bit mask, and the caller flips that bit in its own buffer. Or the error cannot be corrected. The block never modifies data itself.

Top module: `ecc_sec_hamming`

## Requirements
- R1: After reset, code_vld_o and res_vld_o are 0.
- R2: code_o[11:0] holds the inverted parities of all data bits whose 12-bit bit address (byte index times 8 plus bit number) has a 0 in the matching position. code_o[23:12] holds the inverted parities for a 1 in that position. code_o[7:0] is the first byte to store.
- R3: A sector of all 8'hFF bytes gives code_o = 24'hFFFFFF.
- R4: A byte accepted with sos_i high is byte 0 of a new sector. Acceptance clears the earlier parities and drops code_vld_o. code_vld_o rises in the cycle after the 512th byte is accepted.
- R5: Cycles with byte_vld_i low do not count. Bytes that arrive after a complete sector without sos_i leave code_o and code_vld_o unchanged.
- R6: chk_i while code_vld_o is high gives a one-cycle res_vld_o pulse in the next cycle. If stored_i equals code_o, status_o is 0 (clean), fix_data_o is 0 and fix_mask_o is 0.
- R7: Let the syndrome be code_o XOR stored_i. If its bits 23:12 XOR bits 11:0 are all ones and syndrome[23:15] is below the sector size, then status_o is 1 (corrected), fix_data_o is 1, fix_byte_o is syndrome[23:15] and fix_mask_o is 1 shifted left by syndrome[14:12].
- R8: A syndrome with exactly one bit set gives status_o 1, fix_data_o 0 and fix_mask_o 0, because the flipped bit is in the stored code.
- R9: Any other nonzero syndrome gives status_o 2 (uncorrectable) with fix_data_o 0.
- R10: chk_i while code_vld_o is low is ignored, and res_vld_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sos_i | input | 1 | Marks the current byte as the first of a sector |
| byte_vld_i | input | 1 | byte_i carries a sector byte |
| byte_i | input | 8 | Sector data byte |
| code_o | output | 24 | Packed, inverted code of the last complete sector |
| code_vld_o | output | 1 | code_o belongs to a complete sector |
| chk_i | input | 1 | Compare stored_i against code_o |
| stored_i | input | 24 | Code read back from storage |
| res_vld_o | output | 1 | Check result valid, one cycle |
| status_o | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| fix_data_o | output | 1 | A data bit must be flipped |
| fix_byte_o | output | 9 | Byte index of the bit to flip |
| fix_mask_o | output | 8 | One-hot mask of the bit to flip |

## Verification
The generator is exercised with four kinds of sector. An erased sector shows that the inversion lines up with blank storage. An arithmetic byte pattern, compared against an independent bit-by-bit model, separates the even half of the code from the odd half and catches swapped address bits. The same pattern with idle gaps, and a sector that restarts partway, show that the byte counter and the clear on sos_i are right. The checker is given single data-bit flips at byte 0, at byte 511 and in the middle, single flips in the stored code in each half, and double and triple errors. Together these separate the three outcomes and test the location fields at their limits.

// File: rtl/ecc_sec_pkg.sv
package ecc_sec_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN  = 2'd0,
    ECC_FIXED  = 2'd1,
    ECC_UNCORR = 2'd2
  } ecc_status_e;

  // bits of a byte whose in-byte position has bit k set
  function automatic logic [7:0] pos_mask(input int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
    return m;
  endfunction

endpackage

// File: rtl/ecc_sec_accum.sv
module ecc_sec_accum
  import ecc_sec_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDX_W  = $clog2(SECTOR_BYTES),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sos_i,
  input  logic              vld_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] odd_o,
  output logic [ADDR_W-1:0] even_o,
  output logic              done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

  logic              active_q, done_q;
  logic [IDX_W-1:0]  cnt_q, idx;
  logic [ADDR_W-1:0] odd_q, even_q, odd_c, even_c, odd_base, even_base;
  logic              accept, last_hit, byte_par;

  assign accept    = vld_i && (sos_i || active_q);
  assign idx       = sos_i ? '0 : cnt_q;
  assign last_hit  = (idx == LAST_IDX);
  assign byte_par  = ^byte_i;
  assign odd_base  = sos_i ? '0 : odd_q;
  assign even_base = sos_i ? '0 : even_q;

  // in-byte address bits
  for (genvar k = 0; k < 3; k++) begin : g_bitpos
    assign odd_c[k]  = ^(byte_i & pos_mask(k));
    assign even_c[k] = ^(byte_i & ~pos_mask(k));
  end

  // byte-index address bits
  for (genvar j = 0; j < IDX_W; j++) begin : g_bytepos
    assign odd_c[3+j]  = idx[j] & byte_par;
    assign even_c[3+j] = ~idx[j] & byte_par;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      odd_q    <= '0;
      even_q   <= '0;
    end else if (accept) begin
      odd_q  <= odd_base ^ odd_c;
      even_q <= even_base ^ even_c;
      done_q <= last_hit;
      if (last_hit) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        active_q <= 1'b1;
        cnt_q    <= idx + IDX_W'(1);
      end
    end
  end

  assign odd_o  = odd_q;
  assign even_o = even_q;
  assign done_o = done_q;

  // R4
  code_vld_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(accept && last_hit));

  // R4
  sos_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sos_i && SECTOR_BYTES > 1) |=> !done_q);

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(odd_q) && $stable(even_q) && $stable(done_q)));

endmodule

// File: rtl/ecc_sec_decode.sv
module ecc_sec_decode
  import ecc_sec_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDX_W  = $clog2(SECTOR_BYTES),
  localparam int ADDR_W = IDX_W + 3,
  localparam int CODE_W = 2 * ADDR_W
) (
  input  logic [CODE_W-1:0] syn_i,
  output ecc_status_e       status_o,
  output logic              fix_data_o,
  output logic [IDX_W-1:0]  fix_byte_o,
  output logic [7:0]        fix_mask_o
);

  logic [ADDR_W-1:0] hi, lo;
  logic              complement, in_range, single, zero;

  assign hi         = syn_i[CODE_W-1:ADDR_W];
  assign lo         = syn_i[ADDR_W-1:0];
  assign complement = &(hi ^ lo);
  assign in_range   = {1'b0, hi[ADDR_W-1:3]} < (IDX_W+1)'(SECTOR_BYTES);
  assign zero       = (syn_i == '0);
  assign single     = !zero && ((syn_i & (syn_i - CODE_W'(1))) == '0);

  always_comb begin
    status_o   = ECC_UNCORR;
    fix_data_o = 1'b0;
    fix_byte_o = '0;
    fix_mask_o = '0;
    if (zero) begin
      status_o = ECC_CLEAN;
    end else if (complement) begin
      if (in_range) begin
        status_o   = ECC_FIXED;
        fix_data_o = 1'b1;
        fix_byte_o = hi[ADDR_W-1:3];
        fix_mask_o = 8'(1) << hi[2:0];
      end
    end else if (single) begin
      status_o = ECC_FIXED;
    end
  end

endmodule

// File: rtl/ecc_sec_hamming.sv
module ecc_sec_hamming
  import ecc_sec_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int IDX_W  = $clog2(SECTOR_BYTES),
  localparam int ADDR_W = IDX_W + 3,
  localparam int CODE_W = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sos_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_vld_o,
  input  logic              chk_i,
  input  logic [CODE_W-1:0] stored_i,
  output logic              res_vld_o,
  output logic [1:0]        status_o,
  output logic              fix_data_o,
  output logic [IDX_W-1:0]  fix_byte_o,
  output logic [7:0]        fix_mask_o
);

  logic [ADDR_W-1:0] odd_par, even_par;
  logic              sector_done;
  ecc_status_e       dec_status;
  logic              dec_fix;
  logic [IDX_W-1:0]  dec_byte;
  logic [7:0]        dec_mask;
  logic              chk_go;

  ecc_sec_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sos_i  (sos_i),
    .vld_i  (byte_vld_i),
    .byte_i (byte_i),
    .odd_o  (odd_par),
    .even_o (even_par),
    .done_o (sector_done)
  );

  // inverted so an erased sector matches erased storage
  assign code_o     = ~{odd_par, even_par};
  assign code_vld_o = sector_done;

  ecc_sec_decode #(.SECTOR_BYTES(SECTOR_BYTES)) u_decode (
    .syn_i      (code_o ^ stored_i),
    .status_o   (dec_status),
    .fix_data_o (dec_fix),
    .fix_byte_o (dec_byte),
    .fix_mask_o (dec_mask)
  );

  assign chk_go = chk_i && sector_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o  <= 1'b0;
      status_o   <= ECC_CLEAN;
      fix_data_o <= 1'b0;
      fix_byte_o <= '0;
      fix_mask_o <= '0;
    end else begin
      res_vld_o <= chk_go;
      if (chk_go) begin
        status_o   <= dec_status;
        fix_data_o <= dec_fix;
        fix_byte_o <= dec_byte;
        fix_mask_o <= dec_mask;
      end
    end
  end

  // R6
  res_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> $past(chk_i && code_vld_o));

  // R6
  clean_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && status_o == ECC_CLEAN) |-> $past(stored_i == code_o));

  // R7
  fix_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && fix_data_o) |-> ($countones(fix_mask_o) == 1 && status_o == ECC_FIXED));

  // R9
  uncorr_nofix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && status_o == ECC_UNCORR) |-> (!fix_data_o && $onehot0(fix_mask_o)));

endmodule

// File: tb/ecc_sec_hamming_bench.sv
`timescale 1ns/1ps
module ecc_sec_hamming_bench;

  localparam int NB = 512;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sos_i = 1'b0, byte_vld_i = 1'b0, chk_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [23:0] stored_i = '0;
  logic [23:0] code_o;
  logic        code_vld_o, res_vld_o, fix_data_o;
  logic [1:0]  status_o;
  logic [8:0]  fix_byte_o;
  logic [7:0]  fix_mask_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] sec [NB];

  always #2 clk_i = ~clk_i;

  ecc_sec_hamming u_ecc_sec_hamming (
    .clk_i, .rst_ni, .sos_i, .byte_vld_i, .byte_i, .code_o, .code_vld_o,
    .chk_i, .stored_i, .res_vld_o, .status_o, .fix_data_o, .fix_byte_o, .fix_mask_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model_code();
    logic [11:0] odd = '0, even = '0;
    for (int i = 0; i < NB; i++)
      for (int b = 0; b < 8; b++)
        if (sec[i][b]) begin
          logic [11:0] a = {i[8:0], b[2:0]};
          for (int k = 0; k < 12; k++)
            if (a[k]) odd[k] = ~odd[k]; else even[k] = ~even[k];
        end
    return ~{odd, even};
  endfunction

  task automatic send_sector(input bit gaps);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk_i);
      byte_vld_i = 1'b1; sos_i = (i == 0); byte_i = sec[i];
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk_i);
        byte_vld_i = 1'b0; sos_i = 1'b0; byte_i = 8'h5A;
      end
    end
    @(negedge clk_i);
    byte_vld_i = 1'b0; sos_i = 1'b0;
  endtask

  task automatic do_check(input logic [23:0] st);
    @(negedge clk_i);
    chk_i = 1'b1; stored_i = st;
    @(negedge clk_i);
    chk_i = 1'b0;
  endtask

  task automatic fill_pattern();
    for (int i = 0; i < NB; i++) sec[i] = 8'(i * 37 + 11);
  endtask

  task automatic t_reset();
    check("R1 code_vld after reset", code_vld_o, 0);
    check("R1 res_vld after reset", res_vld_o, 0);
    do_check(24'h0);
    check("R10 chk ignored without code", res_vld_o, 0);
  endtask

  task automatic t_erased();
    for (int i = 0; i < NB; i++) sec[i] = 8'hFF;
    send_sector(0);
    check("R4 code_vld after sector", code_vld_o, 1);
    check("R3 erased code", code_o, 24'hFFFFFF);
    do_check(24'hFFFFFF);
    check("R6 res_vld", res_vld_o, 1);
    check("R6 erased clean status", status_o, 0);
    @(negedge clk_i);
    check("R6 res_vld one cycle", res_vld_o, 0);
  endtask

  task automatic t_pattern();
    logic [23:0] g;
    fill_pattern();
    g = model_code();
    send_sector(0);
    check("R2 pattern code", code_o, g);
    do_check(g);
    check("R6 pattern clean", {status_o, fix_data_o, fix_mask_o}, 0);
    send_sector(1);
    check("R5 code with gaps", code_o, g);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      byte_vld_i = 1'b1; byte_i = 8'(i + 1);
    end
    @(negedge clk_i);
    byte_vld_i = 1'b0;
    check("R5 extra bytes ignored code", code_o, g);
    check("R5 extra bytes ignored vld", code_vld_o, 1);
  endtask

  task automatic t_restart();
    logic [23:0] g;
    fill_pattern();
    g = model_code();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      byte_vld_i = 1'b1; sos_i = (i == 0); byte_i = 8'(i * 13 + 7);
    end
    @(negedge clk_i);
    byte_vld_i = 1'b0; sos_i = 1'b0;
    check("R4 sos drops code_vld", code_vld_o, 0);
    send_sector(0);
    check("R4 restart code", code_o, g);
  endtask

  task automatic t_data_flip(input int bi, input int bb);
    logic [23:0] g;
    fill_pattern();
    g = model_code();
    sec[bi][bb] = ~sec[bi][bb];
    send_sector(0);
    do_check(g);
    check("R7 status", status_o, 1);
    check("R7 fix_data", fix_data_o, 1);
    check("R7 fix_byte", fix_byte_o, bi);
    check("R7 fix_mask", fix_mask_o, 32'(1) << bb);
  endtask

  task automatic t_code_flip();
    logic [23:0] g;
    fill_pattern();
    g = model_code();
    send_sector(0);
    do_check(g ^ 24'h020000);
    check("R8 upper code bit status", status_o, 1);
    check("R8 upper code bit no data fix", {fix_data_o, fix_mask_o}, 0);
    do_check(g ^ 24'h000008);
    check("R8 lower code bit status", status_o, 1);
    check("R8 lower code bit no data fix", {fix_data_o, fix_mask_o}, 0);
  endtask

  task automatic t_uncorr();
    logic [23:0] g;
    fill_pattern();
    g = model_code();
    sec[10][1] = ~sec[10][1];
    sec[400][6] = ~sec[400][6];
    send_sector(0);
    do_check(g);
    check("R9 double data error", status_o, 2);
    check("R9 double no fix", fix_data_o, 0);
    fill_pattern();
    send_sector(0);
    do_check(g ^ 24'h000007);
    check("R9 three code bits", status_o, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_erased();
    t_pattern();
    t_restart();
    t_data_flip(300, 5);
    t_data_flip(511, 7);
    t_data_flip(0, 0);
    t_code_flip();
    t_uncorr();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule